// File: doc/BRIEF.md
# Phase-Ordered Commit Arbiter

This block decides which processor in a transactional multiprocessor may broadcast its buffered writes to shared memory. Only one processor holds commit permission at any time. That permission is exclusive, so the order in which it is handed out becomes the order in which transactions appear to execute across the whole system.

Each processor marks whether it is running a transaction and supplies that transaction's phase number. The block takes the smallest phase among all active processors as the oldest phase. Only requesters carrying that phase can win. Giving every transaction its own increasing phase forces strict program order. Giving a group of transactions the same phase lets them commit in any order, which acts as a barrier between groups.

A processor may raise its request long before it finishes. It does this before consuming input, or when its output must stay ordered. Once granted, it keeps permission through the rest of its transaction, so it can never be rolled back after that point. Permission ends only when the holder pulses done.

Top module: `phase_commit_arbiter`

## Requirements
- R1: At most one bit of `grant_o` is high in any cycle.
- R2: Once a grant is issued, `grant_o` stays unchanged until the holder raises its done bit. This holds even if the holder drops its request or stops running, so a permission requested early lasts through the whole transaction.
- R3: A new grant goes only to a processor whose request was high on the clock edge that issued it. Its phase, taken from bits `[i*PW +: PW]` of `phase_i`, must equal the minimum phase over active processors on that edge. A processor counts as active when its run or request bit is high. Phases compare as unsigned numbers.
- R4: A requester with a newer phase is not granted while any active processor, requesting or not, holds an older phase. It becomes eligible once no active processor remains in that older phase.
- R5: Among eligible requesters, the search begins at the index one above the last grantee and wraps from N-1 to 0.
- R6: A done bit from a processor that does not hold the grant has no effect.
- R7: When the holder's done bit is high on a clock edge, `grant_o` becomes zero on that edge and remains zero for at least one cycle.
- R8: While `rst` is high, and right after it falls, `grant_o` is zero and the rotating search starts at index 0.
- R9: When `grant_o` is zero on an edge and at least one eligible requester exists, a grant appears on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | N | Processor is executing a transaction |
| req_i | input | N | Processor asks for commit permission |
| phase_i | input | N*PW | Phase number per processor, processor i in bits [i*PW +: PW] |
| done_i | input | N | Processor has finished its commit |
| grant_o | output | N | One-hot commit permission, registered |

## Verification
Several properties are checked on every clock cycle: grant exclusivity, holding the grant until done, the idle cycle after release, and the rule that every new grant goes to an oldest-phase requester. No eligible requester may ever be left waiting while the grant is idle. Only the bench's scenarios can show the rest. These are the exact rotation order, an older non-requesting processor blocking newer ones, stray done pulses being ignored, and a chain of distinct phases committing in strict order.

// File: rtl/pca_pkg.sv
package pca_pkg;
  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_HELD = 1'b1
  } arb_state_t;
endpackage

// File: rtl/pca_oldest_phase.sv
module pca_oldest_phase #(
  parameter int N  = 4,
  parameter int PW = 4
) (
  input  logic [N-1:0]    act_i,
  input  logic [N*PW-1:0] phase_i,
  output logic [PW-1:0]   min_o,
  output logic            any_o
);
  always_comb begin
    min_o = '1;
    any_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (act_i[i] && (!any_o || phase_i[i*PW +: PW] < min_o)) begin
        min_o = phase_i[i*PW +: PW];
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pca_rr_pick.sv
module pca_rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  elig_i,
  input  logic [IW-1:0] ptr_i,
  output logic          found_o,
  output logic [IW-1:0] win_o
);
  int j;
  always_comb begin
    found_o = 1'b0;
    win_o   = '0;
    j       = 0;
    for (int k = 0; k < N; k++) begin
      j = int'(ptr_i) + k;
      if (j >= N) j = j - N;
      if (!found_o && elig_i[j]) begin
        found_o = 1'b1;
        win_o   = IW'(j);
      end
    end
  end
endmodule

// File: rtl/phase_commit_arbiter.sv
module phase_commit_arbiter #(
  parameter int N  = 4,
  parameter int PW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    run_i,
  input  logic [N-1:0]    req_i,
  input  logic [N*PW-1:0] phase_i,
  input  logic [N-1:0]    done_i,
  output logic [N-1:0]    grant_o
);
  import pca_pkg::*;

  localparam int IW = (N < 2) ? 1 : $clog2(N);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  arb_state_t    st_q;
  logic [IW-1:0] holder_q;
  logic [IW-1:0] ptr_q;
  logic [N-1:0]  grant_q;

  logic [N-1:0]  active;
  logic [N-1:0]  elig;
  logic [PW-1:0] oldest;
  logic          any_act;
  logic          found;
  logic [IW-1:0] win;

  assign active = run_i | req_i;

  pca_oldest_phase #(.N(N), .PW(PW)) u_oldest (
    .act_i   (active),
    .phase_i (phase_i),
    .min_o   (oldest),
    .any_o   (any_act)
  );

  for (genvar g = 0; g < N; g++) begin : g_elig
    assign elig[g] = req_i[g] && any_act && (phase_i[g*PW +: PW] == oldest);
  end

  pca_rr_pick #(.N(N), .IW(IW)) u_pick (
    .elig_i  (elig),
    .ptr_i   (ptr_q),
    .found_o (found),
    .win_o   (win)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ARB_IDLE;
      holder_q <= '0;
      ptr_q    <= '0;
      grant_q  <= '0;
    end else begin
      case (st_q)
        ARB_IDLE: begin
          if (found) begin
            st_q     <= ARB_HELD;
            holder_q <= win;
            grant_q  <= {{(N-1){1'b0}}, 1'b1} << win;
            ptr_q    <= (win == LAST) ? '0 : win + 1'b1;
          end
        end
        default: begin
          if (done_i[holder_q]) begin
            st_q    <= ARB_IDLE;
            grant_q <= '0;
          end
        end
      endcase
    end
  end

  assign grant_o = grant_q;
endmodule

// File: rtl/pca_checker.sv
module pca_checker #(
  parameter int N  = 4,
  parameter int PW = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [N-1:0]    run_i,
  input logic [N-1:0]    req_i,
  input logic [N*PW-1:0] phase_i,
  input logic [N-1:0]    done_i,
  input logic [N-1:0]    grant_o
);
  logic [PW-1:0] c_min;
  logic          c_any;
  logic [N-1:0]  c_ok;

  always_comb begin
    c_min = '1;
    c_any = 1'b0;
    for (int i = 0; i < N; i++)
      if ((run_i[i] || req_i[i]) && (!c_any || phase_i[i*PW +: PW] < c_min)) begin
        c_min = phase_i[i*PW +: PW];
        c_any = 1'b1;
      end
    for (int i = 0; i < N; i++)
      c_ok[i] = req_i[i] && c_any && phase_i[i*PW +: PW] == c_min;
  end

  assert_single_grant_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));

  assert_hold_until_done_R2: assert property (@(posedge clk) disable iff (rst)
    (grant_o != '0 && (done_i & grant_o) == '0) |=> grant_o == $past(grant_o));

  assert_oldest_phase_only_R3: assert property (@(posedge clk) disable iff (rst)
    (grant_o != '0 && $past(grant_o) == '0) |-> (grant_o & $past(c_ok)) == grant_o);

  assert_release_gap_R7: assert property (@(posedge clk) disable iff (rst)
    (grant_o != '0 && (done_i & grant_o) != '0) |=> grant_o == '0);

  assert_no_idle_with_eligible_R9: assert property (@(posedge clk) disable iff (rst)
    (grant_o == '0 && c_ok != '0) |=> grant_o != '0);
endmodule

bind phase_commit_arbiter pca_checker #(.N(N), .PW(PW)) u_pca_checker (
  .clk     (clk),
  .rst     (rst),
  .run_i   (run_i),
  .req_i   (req_i),
  .phase_i (phase_i),
  .done_i  (done_i),
  .grant_o (grant_o)
);

// File: tb/tb_phase_commit_arbiter.sv
module tb_phase_commit_arbiter;
  localparam int N  = 4;
  localparam int PW = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    run = '0;
  logic [N-1:0]    req = '0;
  logic [N*PW-1:0] phase = '0;
  logic [N-1:0]    done = '0;
  logic [N-1:0]    grant;

  int n_chk = 0;
  int n_bad = 0;
  string cur = "R8";

  int m_hold = -1;
  int m_ptr  = 0;

  always #5 clk = ~clk;

  phase_commit_arbiter #(.N(N), .PW(PW)) dut (
    .clk(clk), .rst(rst), .run_i(run), .req_i(req),
    .phase_i(phase), .done_i(done), .grant_o(grant)
  );

  function automatic logic [N-1:0] m_vec();
    return (m_hold < 0) ? '0 : (N'(1) << m_hold);
  endfunction

  task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: grant actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: updated at each rising edge from stable inputs.
  always @(posedge clk) begin
    if (rst) begin
      m_hold = -1;
      m_ptr  = 0;
    end else if (m_hold >= 0) begin
      if (done[m_hold]) m_hold = -1;
    end else begin
      int mn;
      mn = -1;
      for (int i = 0; i < N; i++)
        if (run[i] || req[i])
          if (mn < 0 || int'(phase[i*PW +: PW]) < mn) mn = int'(phase[i*PW +: PW]);
      for (int k = 0; k < N; k++) begin
        int j;
        j = (m_ptr + k) % N;
        if (m_hold < 0 && req[j] && int'(phase[j*PW +: PW]) == mn) begin
          m_hold = j;
          m_ptr  = (j + 1) % N;
        end
      end
    end
  end

  always @(negedge clk) begin
    check(grant, m_vec(), cur);
    n_chk++;
    if ($countones(grant) > 1) begin
      n_bad++;
      $display("FAIL R1: grant actual %b expected at most one bit", grant);
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic set_ph(input int i, input int v);
    phase[i*PW +: PW] = PW'(v);
  endtask

  task automatic release_grant(input int i);
    done[i] = 1'b1; req[i] = 1'b0; run[i] = 1'b0;
    step();
    done[i] = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R8 reset
    repeat (3) step();
    check(grant, '0, "R8");
    rst = 1'b0;
    step();
    check(grant, '0, "R8");

    // R9: single requester granted on next edge
    cur = "R9";
    set_ph(0, 2); run[0] = 1'b1; req[0] = 1'b1;
    step();
    check(grant, 4'b0001, "R9");

    // R6: stray done from a non-holder
    cur = "R6";
    done[1] = 1'b1;
    repeat (2) step();
    check(grant, 4'b0001, "R6");
    done[1] = 1'b0;

    // R2: early permission kept although the request drops
    cur = "R2";
    req[0] = 1'b0;
    repeat (3) step();
    check(grant, 4'b0001, "R2");

    // R7: release, idle cycle, then next grant
    cur = "R7";
    set_ph(1, 2); run[1] = 1'b1; req[1] = 1'b1;
    release_grant(0);
    check(grant, '0, "R7");
    step();
    check(grant, 4'b0010, "R7");

    // R4: older non-requesting processor blocks newer requester
    cur = "R4";
    set_ph(2, 1); run[2] = 1'b1;
    set_ph(3, 3); run[3] = 1'b1; req[3] = 1'b1;
    release_grant(1);
    repeat (3) step();
    check(grant, '0, "R4");
    run[2] = 1'b0;
    step();
    check(grant, 4'b1000, "R4");

    // R5: rotation among equal phases, starting after index 3
    cur = "R5";
    for (int i = 0; i < N; i++) begin
      set_ph(i, 5); run[i] = 1'b1; req[i] = 1'b1;
    end
    release_grant(3);
    run[3] = 1'b1; req[3] = 1'b1;
    step();
    check(grant, 4'b0001, "R5");
    for (int r = 1; r < 5; r++) begin
      int w;
      w = (r - 1) % N;
      release_grant(w);
      run[w] = 1'b1; req[w] = 1'b1;
      step();
      check(grant, N'(1) << (r % N), "R5");
    end

    // R3: distinct phases commit strictly oldest first
    cur = "R3";
    release_grant(0);
    set_ph(3, 6); set_ph(2, 7); set_ph(1, 8); set_ph(0, 9);
    run = '1; req = '1;
    step();
    check(grant, 4'b1000, "R3");
    for (int p = 2; p >= 0; p--) begin
      release_grant(p + 1);
      step();
      check(grant, N'(1) << p, "R3");
    end
    release_grant(0);
    repeat (3) step();
    check(grant, '0, "R3");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule